// File: doc/BRIEF.md
# Multiple-Register Transfer Address Sequencer

This block drives the memory side of a load-multiple or store-multiple operation. It transfers between a bank of sixteen 32-bit registers and word-addressed memory. A caller gives it a start pulse together with five inputs:

- a base byte address;
- a 16-bit selection mask, where bit i picks register i;
- a step direction (up or down);
- a timing choice, which says whether the step is applied before or after each access;
- a load/store flag and a writeback flag.

The block then issues one memory request per selected register over a valid/ready handshake. Each request carries a word address and the index of the register that feeds or receives that word.

Registers always go out lowest index first, and the lowest index always gets the lowest address, whatever the direction. In the downward modes the block therefore computes the bottom of the block up front and walks upward from it. When the last beat has been accepted, the block pulses a completion strobe. If writeback was asked for, it also presents the updated base in that same cycle. A stack push is the downward, step-before form with writeback. A stack pop is the upward, step-after form with writeback.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, busy_o, req_valid_o, done_o and wb_valid_o are all 0, and req_valid_o is never 1 while busy_o is 0.
- R2: Selected registers are requested in strictly ascending index order. Each mask bit set to 1 gives exactly one request, with req_idx_o equal to that bit position, and gaps in the mask are skipped.
- R3: Upward, step-after mode (incr_i=1, before_i=0): the first address is the base, and each following address is 4 higher.
- R4: Upward, step-before mode (incr_i=1, before_i=1): the first address is base+4, and each following address is 4 higher.
- R5: Downward, step-after mode (incr_i=0, before_i=0): with N selected registers, the first address (lowest index) is base−4N+4, and each following address is 4 higher.
- R6: Downward, step-before mode (incr_i=0, before_i=1): the first address is base−4N, and each following address is 4 higher.
- R7: In the done cycle, wb_valid_o equals the latched writeback flag. When it is 1, wb_addr_o is base+4N for upward modes and base−4N for downward modes. Outside a valid writeback, wb_addr_o is 0 and wb_valid_o is 0.
- R8: An all-zero mask issues no request. done_o rises in the cycle after the start, and any writeback value equals the unchanged base.
- R9: While req_valid_o is 1 and req_ready_i is 0, req_valid_o stays 1, and req_addr_o and req_idx_o hold their values.
- R10: done_o is 1 for exactly one cycle, the cycle after the last accepted beat. busy_o falls in the cycle after that.
- R11: A start pulse while busy_o is 1 is ignored. The running transfer's addresses, indices and count are unchanged, and no second transfer follows.
- R12: req_load_o equals the load flag latched at start for every beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a transfer (sampled only when idle) |
| base_i | input | 32 | Base byte address |
| mask_i | input | 16 | Register selection, bit i picks register i |
| incr_i | input | 1 | 1 = step upward, 0 = step downward |
| before_i | input | 1 | 1 = step applied before each access, 0 = after |
| load_i | input | 1 | 1 = memory to registers, 0 = registers to memory |
| wb_i | input | 1 | Report the updated base at completion |
| busy_o | output | 1 | Transfer in progress |
| req_valid_o | output | 1 | Memory request valid |
| req_ready_i | input | 1 | Memory accepts the request |
| req_addr_o | output | 32 | Word byte address of the current beat |
| req_idx_o | output | 4 | Register index of the current beat |
| req_load_o | output | 1 | Direction of the current beat |
| done_o | output | 1 | One-cycle completion strobe |
| wb_valid_o | output | 1 | Writeback value valid (with done_o) |
| wb_addr_o | output | 32 | Updated base value |

## Verification
The bench targets the downward modes. An off-by-one there would start four bytes high or low, or would hand the highest address to the lowest register. Sparse masks, a full mask that wraps to address zero, and a push followed by a pop would expose a contiguous counter or a wrong count. A stall on the first beat catches an address that advances without a handshake. A start pulse during a stall catches a sequencer that reloads mid-transfer. The empty mask catches a design that hangs, or one that emits a bogus request for register zero.

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int ADDR_W = 32,
  parameter int NREG   = 16,
  parameter int STEP   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic [ADDR_W-1:0]         base_i,
  input  logic [NREG-1:0]           mask_i,
  input  logic                      incr_i,
  input  logic                      before_i,
  input  logic                      load_i,
  input  logic                      wb_i,
  output logic                      busy_o,
  output logic                      req_valid_o,
  input  logic                      req_ready_i,
  output logic [ADDR_W-1:0]         req_addr_o,
  output logic [$clog2(NREG)-1:0]   req_idx_o,
  output logic                      req_load_o,
  output logic                      done_o,
  output logic                      wb_valid_o,
  output logic [ADDR_W-1:0]         wb_addr_o
);
  localparam int IDX_W = $clog2(NREG);
  localparam int CNT_W = $clog2(NREG + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;
  st_t st_q;

  logic [NREG-1:0]   rem_q;
  logic [ADDR_W-1:0] addr_q, fin_q;
  logic              load_q, wb_q;

  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] span, first_addr, last_base;
  logic [IDX_W-1:0]  low_idx;
  logic              fire, last_beat;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NREG; i++) cnt = cnt + CNT_W'(mask_i[i]);
  end

  always_comb begin
    low_idx = '0;
    for (int i = NREG - 1; i >= 0; i--) if (rem_q[i]) low_idx = IDX_W'(i);
  end

  assign span       = ADDR_W'(cnt) * ADDR_W'(STEP);
  assign last_base  = incr_i ? base_i + span : base_i - span;
  assign first_addr = incr_i ? (before_i ? base_i + ADDR_W'(STEP) : base_i)
                             : (before_i ? base_i - span
                                         : base_i - span + ADDR_W'(STEP));

  assign fire      = req_valid_o && req_ready_i;
  assign last_beat = (rem_q & (rem_q - NREG'(1))) == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      rem_q  <= '0;
      addr_q <= '0;
      fin_q  <= '0;
      load_q <= 1'b0;
      wb_q   <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (start_i) begin
          rem_q  <= mask_i;
          addr_q <= first_addr;
          fin_q  <= last_base;
          load_q <= load_i;
          wb_q   <= wb_i;
          st_q   <= (mask_i == '0) ? S_FIN : S_RUN;
        end
        S_RUN: if (fire) begin
          rem_q[low_idx] <= 1'b0;
          addr_q         <= addr_q + ADDR_W'(STEP);
          if (last_beat) st_q <= S_FIN;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = st_q != S_IDLE;
  assign req_valid_o = st_q == S_RUN;
  assign req_addr_o  = addr_q;
  assign req_idx_o   = low_idx;
  assign req_load_o  = load_q & req_valid_o;
  assign done_o      = st_q == S_FIN;
  assign wb_valid_o  = done_o & wb_q;
  assign wb_addr_o   = wb_valid_o ? fin_q : '0;
endmodule

// File: rtl/blk_xfer_seq_chk.sv
module blk_xfer_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic [IDX_W-1:0]  req_idx_o,
  input logic              done_o,
  input logic              wb_valid_o
);
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !req_valid_o); // R1
  AST_IDX_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_ready_i) |=> (!req_valid_o || req_idx_o > $past(req_idx_o))); // R2
  AST_ADDR_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_ready_i) |=> (!req_valid_o || req_addr_o == $past(req_addr_o) + ADDR_W'(4))); // R3
  AST_WB_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> !wb_valid_o); // R7
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o) && $stable(req_idx_o))); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o)); // R10
endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(.ADDR_W(ADDR_W), .IDX_W($clog2(NREG))) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .req_valid_o(req_valid_o),
  .req_ready_i(req_ready_i), .req_addr_o(req_addr_o), .req_idx_o(req_idx_o),
  .done_o(done_o), .wb_valid_o(wb_valid_o)
);

// File: tb/tb_blk_xfer_seq.sv
`timescale 1ns/1ps
module tb_blk_xfer_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] mask_i = '0;
  logic        incr_i = 1'b0, before_i = 1'b0, load_i = 1'b0, wb_i = 1'b0;
  logic        req_ready_i = 1'b0;
  logic        busy_o, req_valid_o, req_load_o, done_o, wb_valid_o;
  logic [31:0] req_addr_o, wb_addr_o;
  logic [3:0]  req_idx_o;
  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  blk_xfer_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i), .mask_i(mask_i),
    .incr_i(incr_i), .before_i(before_i), .load_i(load_i), .wb_i(wb_i),
    .busy_o(busy_o), .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
    .req_addr_o(req_addr_o), .req_idx_o(req_idx_o), .req_load_o(req_load_o),
    .done_o(done_o), .wb_valid_o(wb_valid_o), .wb_addr_o(wb_addr_o)
  );

  // base[51:20] mask[19:4] incr[3] before[2] load[1] wb[0]
  localparam logic [51:0] VEC [0:5] = '{
    {32'h0000_03E8, 16'h05D0, 4'b1011},
    {32'h0000_2000, 16'h8001, 4'b1100},
    {32'h0000_0100, 16'h00F0, 4'b0011},
    {32'h0000_8000, 16'h403A, 4'b0101},
    {32'h0000_7FEC, 16'h403A, 4'b1011},
    {32'h0000_0040, 16'hFFFF, 4'b0111}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string mode_tag(input logic inc, input logic bef);
    if (inc) return bef ? "R4 addr" : "R3 addr";
    return bef ? "R6 addr" : "R5 addr";
  endfunction

  task automatic run(input logic [31:0] b, input logic [15:0] m, input logic inc,
                     input logic bef, input logic ld, input logic wb, input logic stall);
    int n = 0;
    int k = 0;
    logic [31:0] a0, fin, held;
    for (int i = 0; i < 16; i++) n += int'(m[i]);
    if (inc) a0 = bef ? b + 32'd4 : b;
    else     a0 = bef ? b - 32'(4*n) : b - 32'(4*n) + 32'd4;
    fin = inc ? b + 32'(4*n) : b - 32'(4*n);
    @(negedge clk);
    base_i = b; mask_i = m; incr_i = inc; before_i = bef; load_i = ld; wb_i = wb; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 16; i++) begin
      if (m[i]) begin
        if (stall && k == 0) begin
          req_ready_i = 1'b0;
          held = req_addr_o;
          @(negedge clk);
          chk("R9 valid held", 32'(req_valid_o), 32'd1);
          chk("R9 addr held", req_addr_o, held);
        end
        req_ready_i = 1'b1;
        chk("R2 valid", 32'(req_valid_o), 32'd1);
        chk("R2 idx", 32'(req_idx_o), 32'(i));
        chk(mode_tag(inc, bef), req_addr_o, a0 + 32'(4*k));
        chk("R12 load", 32'(req_load_o), 32'(ld));
        @(negedge clk);
        req_ready_i = 1'b0;
        k++;
      end
    end
    chk("R10 done", 32'(done_o), 32'd1);
    chk("R8 no req at done", 32'(req_valid_o), 32'd0);
    chk("R7 wb valid", 32'(wb_valid_o), 32'(wb));
    chk("R7 wb addr", wb_addr_o, wb ? fin : 32'd0);
    @(negedge clk);
    chk("R10 done pulse", 32'(done_o), 32'd0);
    chk("R10 busy low", 32'(busy_o), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", 32'(busy_o), 32'd0);
    chk("R1 valid", 32'(req_valid_o), 32'd0);
    chk("R1 done", 32'(done_o), 32'd0);
    chk("R1 wb valid", 32'(wb_valid_o), 32'd0);

    for (int v = 0; v < 6; v++)
      run(VEC[v][51:20], VEC[v][19:4], VEC[v][3], VEC[v][2], VEC[v][1], VEC[v][0], 1'b0);

    // R8: empty mask, upward and downward
    run(32'h0000_1234, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    run(32'h0000_1234, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);

    // R9: stall on first beat
    run(32'h0000_0500, 16'h0204, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);

    // R11: start during a stalled transfer
    @(negedge clk);
    base_i = 32'h10; mask_i = 16'h0003; incr_i = 1'b1; before_i = 1'b0;
    load_i = 1'b1; wb_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    base_i = 32'h900; mask_i = 16'h8000; incr_i = 1'b0; before_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R11 addr kept", req_addr_o, 32'h10);
    chk("R11 idx kept", 32'(req_idx_o), 32'd0);
    req_ready_i = 1'b1;
    @(negedge clk);
    chk("R11 second idx", 32'(req_idx_o), 32'd1);
    chk("R11 second addr", req_addr_o, 32'h14);
    @(negedge clk);
    req_ready_i = 1'b0;
    chk("R11 done", 32'(done_o), 32'd1);
    chk("R11 wb addr", wb_addr_o, 32'h18);
    @(negedge clk);
    chk("R11 no restart", 32'(busy_o), 32'd0);
    @(negedge clk);
    chk("R11 no req", 32'(req_valid_o), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule